// File: doc/BRIEF.md
# MSI Snooping Coherence Line Controller

This block keeps the coherence state of a small private write-back cache that shares a snooping bus with other caches. Each line holds a tag, one data word and one of three states: Invalid (no copy), Shared (a read-only copy that other caches may also hold) or Modified (the only valid copy, which may be written). The cache is direct mapped. The low address bits select the line and the remaining bits form the tag. Only one cache at a time may hold a line in Modified, so a store must first gain exclusive ownership on the bus. A dirty line reaches memory only when it is written back.

The local processor issues load, store and evict requests one at a time. When a request needs the bus, the block raises a request with a command, an address and write data, and waits for a grant from an external arbiter. While it waits it keeps watching the bus. Every transaction from another cache is looked up in the line array and applied at once. After any snoop the waiting request is worked out again from the updated line state, so the command it asks for can change or disappear. When a snooped read or read-exclusive hits a Modified line, this cache answers one cycle later on a separate reply channel with the owned data.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_ready` is 1 and `bus_req`, `cpu_done` and `rply_valid` are 0, so the first load to any address requests a bus read.
- R2: A load that misses (the line is Invalid or holds another tag that is not Modified) raises `bus_req` with `bus_cmd` = 1 (read) and the request address. On the grant edge the line becomes Shared and holds `bus_fill`. `cpu_done` follows one clock later with `cpu_rdata` = `bus_fill`. Whenever `bus_req` is 1, `bus_cmd` lies in 1..4.
- R3: A store that misses raises `bus_cmd` = 2 (read-exclusive). On grant the line becomes Modified and holds the store data, so a later load hits and returns that data.
- R4: A store to a Shared line raises `bus_cmd` = 3 (invalidate). On grant the line becomes Modified and takes the store data.
- R5: A load to a Shared or Modified line, or a store to a Modified line, raises no bus request. `cpu_done` is high for one cycle on the second clock edge after the accepting edge, with `cpu_ready` already back at 1. A load returns the line data.
- R6: Evicting a Modified line raises `bus_cmd` = 4 (write-back) with the line address and data, and leaves the line Invalid after the grant. Evicting a Shared line invalidates it without any bus request. Evicting an absent line completes without any bus request.
- R7: A load or store whose line holds a different tag in Modified first raises a write-back (cmd 4) for the victim's address and data. After that grant it raises the miss command for the new address, and `cpu_done` follows only the second grant.
- R8: A snooped read (`snp_cmd` = 1) that hits a Modified line raises `rply_valid` on the next cycle with the snooped address and the line data, and leaves the line Shared. A later store then needs an invalidate.
- R9: A snooped read-exclusive (`snp_cmd` = 2) that hits a Modified line produces the same reply and leaves the line Invalid. If it hits a Shared line it invalidates the line with no reply.
- R10: A snooped invalidate (`snp_cmd` = 3) that hits a valid line makes it Invalid. Snooped write-back (4) or reply (5) commands, and any snoop whose tag does not match the held line, change nothing and produce no reply.
- R11: In a cycle with `snp_valid` high the pending local request does not advance, and a `bus_gnt` in that cycle is ignored. On the next cycle the request is worked out again from the updated line, so a pending invalidate becomes a read-exclusive if the snoop took the line away.
- R12: A request is taken only when `cpu_valid` and `cpu_ready` are both high. `cpu_ready` is low and `cpu_valid` is ignored while a request is pending. `bus_req` is 0 while `cpu_ready` is 1. A raised request keeps its command and address until a grant or a snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Block idle and able to take a request |
| cpu_op | input | 2 | 0 load, 1 store, 2 evict, 3 treated as load |
| cpu_addr | input | ADDR_W | Request word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_done | output | 1 | One-cycle pulse when a request completes |
| cpu_rdata | output | DATA_W | Line data at completion (load result) |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 3 | 1 read, 2 read-exclusive, 3 invalidate, 4 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data (store data otherwise) |
| bus_gnt | input | 1 | Arbiter grant; the transaction takes effect on this edge |
| bus_fill | input | DATA_W | Line data returned with a read grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 3 | Snooped command, same encoding plus 5 for reply |
| snp_addr | input | ADDR_W | Snooped address |
| rply_valid | output | 1 | This cache supplies owned data |
| rply_addr | output | ADDR_W | Address of the supplied line |
| rply_data | output | DATA_W | Supplied data |

## Verification
The hardest case to reach is a snoop that lands while a local request is waiting for its grant, because the waiting request must then change or drop its bus command. The bench reaches it by holding back the grant on purpose. It places a read-exclusive snoop to the same line in the very cycle the grant finally arrives, and confirms that the grant is ignored and that the command turns from invalidate into read-exclusive. A long random phase then mixes aliasing addresses, random grants and random snoops against a behavioural model compared on every clock.

// File: rtl/msi_pkg.sv
package msi_pkg;

   typedef enum logic [1:0] {
      LN_INV = 2'd0,
      LN_SHR = 2'd1,
      LN_MOD = 2'd2
   } ln_state_t;

   typedef enum logic [2:0] {
      CMD_NONE  = 3'd0,
      CMD_RD    = 3'd1,
      CMD_RDX   = 3'd2,
      CMD_INV   = 3'd3,
      CMD_WB    = 3'd4,
      CMD_REPLY = 3'd5
   } bus_cmd_t;

   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_STORE = 2'd1,
      OP_EVICT = 2'd2,
      OP_SPARE = 2'd3
   } cpu_op_t;

   typedef enum logic [1:0] {
      SRC_KEEP  = 2'd0,
      SRC_FILL  = 2'd1,
      SRC_WDATA = 2'd2
   } dsrc_t;

endpackage

// File: rtl/msi_local_plan.sv
// Decides what a pending processor request needs, given the addressed line.
module msi_local_plan
   import msi_pkg::*;
(
   input  cpu_op_t   op,
   input  ln_state_t st,
   input  logic      tag_hit,
   output bus_cmd_t  cmd,
   output logic      victim,
   output ln_state_t nst,
   output dsrc_t     dsrc,
   output logic      wr
);

   ln_state_t eff;

   always_comb begin
      eff    = tag_hit ? st : LN_INV;
      cmd    = CMD_NONE;
      victim = 1'b0;
      nst    = st;
      dsrc   = SRC_KEEP;
      wr     = 1'b0;
      if (!tag_hit && st == LN_MOD && op != OP_EVICT) begin
         // dirty line of another tag must leave first
         cmd    = CMD_WB;
         victim = 1'b1;
         nst    = LN_INV;
         wr     = 1'b1;
      end else begin
         case (op)
            OP_STORE: begin
               nst  = LN_MOD;
               dsrc = SRC_WDATA;
               wr   = 1'b1;
               if (eff == LN_INV)      cmd = CMD_RDX;
               else if (eff == LN_SHR) cmd = CMD_INV;
            end
            OP_EVICT: begin
               if (eff == LN_MOD) begin
                  cmd = CMD_WB;
                  nst = LN_INV;
                  wr  = 1'b1;
               end else if (eff == LN_SHR) begin
                  nst = LN_INV;
                  wr  = 1'b1;
               end
            end
            default: begin
               if (eff == LN_INV) begin
                  cmd  = CMD_RD;
                  nst  = LN_SHR;
                  dsrc = SRC_FILL;
                  wr   = 1'b1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/msi_snoop_plan.sv
// Reaction of one line to a transaction issued by another cache.
module msi_snoop_plan
   import msi_pkg::*;
(
   input  bus_cmd_t  scmd,
   input  ln_state_t st,
   input  logic      tag_hit,
   output logic      upd,
   output ln_state_t nst,
   output logic      reply
);

   always_comb begin
      nst   = st;
      reply = 1'b0;
      if (tag_hit && st != LN_INV) begin
         case (scmd)
            CMD_RD: begin
               if (st == LN_MOD) begin
                  nst   = LN_SHR;
                  reply = 1'b1;
               end
            end
            CMD_RDX: begin
               nst   = LN_INV;
               reply = (st == LN_MOD);
            end
            CMD_INV: nst = LN_INV;
            default: nst = st;
         endcase
      end
      upd = (nst != st);
   end

endmodule

// File: rtl/msi_line_array.sv
// Direct-mapped tag/state/data storage with a local and a snoop read port.
module msi_line_array
   import msi_pkg::*;
#(
   parameter int LINES  = 4,
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  loc_idx,
   input  logic [IDX_W-1:0]  sn_idx,
   input  logic              wr_en,
   input  ln_state_t         wr_st,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              sn_en,
   input  ln_state_t         sn_st,
   output ln_state_t         loc_st,
   output logic [TAG_W-1:0]  loc_tag,
   output logic [DATA_W-1:0] loc_data,
   output ln_state_t         sn_rd_st,
   output logic [TAG_W-1:0]  sn_rd_tag,
   output logic [DATA_W-1:0] sn_rd_data
);

   ln_state_t         st_w   [LINES];
   logic [TAG_W-1:0]  tag_w  [LINES];
   logic [DATA_W-1:0] data_w [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      ln_state_t         st_q;
      logic [TAG_W-1:0]  tag_q;
      logic [DATA_W-1:0] data_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q   <= LN_INV;
            tag_q  <= '0;
            data_q <= '0;
         end else if (sn_en && sn_idx == IDX_W'(g)) begin
            st_q <= sn_st;
         end else if (wr_en && loc_idx == IDX_W'(g)) begin
            st_q   <= wr_st;
            tag_q  <= wr_tag;
            data_q <= wr_data;
         end
      end

      assign st_w[g]   = st_q;
      assign tag_w[g]  = tag_q;
      assign data_w[g] = data_q;
   end

   assign loc_st     = st_w[loc_idx];
   assign loc_tag    = tag_w[loc_idx];
   assign loc_data   = data_w[loc_idx];
   assign sn_rd_st   = st_w[sn_idx];
   assign sn_rd_tag  = tag_w[sn_idx];
   assign sn_rd_data = data_w[sn_idx];

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
   import msi_pkg::*;
#(
   parameter int LINES  = 4,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   output logic              cpu_ready,
   input  logic [1:0]        cpu_op,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   output logic [2:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic [DATA_W-1:0] bus_fill,
   input  logic              snp_valid,
   input  logic [2:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              rply_valid,
   output logic [ADDR_W-1:0] rply_addr,
   output logic [DATA_W-1:0] rply_data
);

   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   typedef enum logic {PH_IDLE, PH_PEND} phase_t;

   phase_t            ph_q;
   logic [1:0]        pend_op_q;
   logic [ADDR_W-1:0] pend_addr_q;
   logic [DATA_W-1:0] pend_wd_q;

   logic [IDX_W-1:0]  loc_idx, sn_idx;
   logic [TAG_W-1:0]  pend_tag, sn_tag;
   ln_state_t         loc_st, sn_rd_st;
   logic [TAG_W-1:0]  loc_tag, sn_rd_tag;
   logic [DATA_W-1:0] loc_data, sn_rd_data;

   bus_cmd_t  ev_cmd;
   logic      ev_victim, ev_wr;
   ln_state_t ev_nst;
   dsrc_t     ev_dsrc;

   logic      sp_upd, sp_reply;
   ln_state_t sp_nst;

   logic              loc_fire, loc_done;
   logic [DATA_W-1:0] new_data;

   assign loc_idx  = pend_addr_q[IDX_W-1:0];
   assign pend_tag = pend_addr_q[ADDR_W-1:IDX_W];
   assign sn_idx   = snp_addr[IDX_W-1:0];
   assign sn_tag   = snp_addr[ADDR_W-1:IDX_W];

   msi_local_plan u_local (
      .op      (cpu_op_t'(pend_op_q)),
      .st      (loc_st),
      .tag_hit (loc_tag == pend_tag),
      .cmd     (ev_cmd),
      .victim  (ev_victim),
      .nst     (ev_nst),
      .dsrc    (ev_dsrc),
      .wr      (ev_wr)
   );

   msi_snoop_plan u_snoop (
      .scmd    (bus_cmd_t'(snp_cmd)),
      .st      (sn_rd_st),
      .tag_hit (sn_rd_tag == sn_tag),
      .upd     (sp_upd),
      .nst     (sp_nst),
      .reply   (sp_reply)
   );

   // a snoop cycle freezes the local request and masks any grant
   assign loc_fire = (ph_q == PH_PEND) && !snp_valid
                     && (ev_cmd == CMD_NONE || bus_gnt);
   assign loc_done = loc_fire && !ev_victim;

   always_comb begin
      case (ev_dsrc)
         SRC_FILL:  new_data = bus_fill;
         SRC_WDATA: new_data = pend_wd_q;
         default:   new_data = loc_data;
      endcase
   end

   msi_line_array #(
      .LINES  (LINES),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
   ) u_lines (
      .clk        (clk),
      .rst_n      (rst_n),
      .loc_idx    (loc_idx),
      .sn_idx     (sn_idx),
      .wr_en      (loc_fire && ev_wr),
      .wr_st      (ev_nst),
      .wr_tag     (pend_tag),
      .wr_data    (new_data),
      .sn_en      (snp_valid && sp_upd),
      .sn_st      (sp_nst),
      .loc_st     (loc_st),
      .loc_tag    (loc_tag),
      .loc_data   (loc_data),
      .sn_rd_st   (sn_rd_st),
      .sn_rd_tag  (sn_rd_tag),
      .sn_rd_data (sn_rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q        <= PH_IDLE;
         pend_op_q   <= '0;
         pend_addr_q <= '0;
         pend_wd_q   <= '0;
         cpu_done    <= 1'b0;
         cpu_rdata   <= '0;
      end else begin
         cpu_done <= loc_done;
         if (loc_done) begin
            cpu_rdata <= new_data;
         end
         if (ph_q == PH_IDLE) begin
            if (cpu_valid) begin
               ph_q        <= PH_PEND;
               pend_op_q   <= cpu_op;
               pend_addr_q <= cpu_addr;
               pend_wd_q   <= cpu_wdata;
            end
         end else if (loc_done) begin
            ph_q <= PH_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rply_valid <= 1'b0;
         rply_addr  <= '0;
         rply_data  <= '0;
      end else begin
         rply_valid <= snp_valid && sp_reply;
         if (snp_valid && sp_reply) begin
            rply_addr <= snp_addr;
            rply_data <= sn_rd_data;
         end
      end
   end

   assign cpu_ready = (ph_q == PH_IDLE);
   assign bus_req   = (ph_q == PH_PEND) && (ev_cmd != CMD_NONE);
   assign bus_cmd   = ev_cmd;
   assign bus_addr  = ev_victim ? {loc_tag, loc_idx} : pend_addr_q;
   assign bus_wdata = (ev_cmd == CMD_WB) ? loc_data : pend_wd_q;

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ready,
   input logic              cpu_done,
   input logic              bus_req,
   input logic [2:0]        bus_cmd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_gnt,
   input logic              snp_valid,
   input logic [2:0]        snp_cmd,
   input logic              rply_valid
);

   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !bus_req);

   assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt && !snp_valid) |=>
         (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

   assert_cmd_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_cmd >= 3'd1 && bus_cmd <= 3'd4));

   assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> cpu_ready);

   assert_reply_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rply_valid |-> ($past(snp_valid) &&
                      ($past(snp_cmd) == 3'd1 || $past(snp_cmd) == 3'd2)));

   assert_snoop_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && bus_gnt) |=> !cpu_done);

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_ready  (cpu_ready),
   .cpu_done   (cpu_done),
   .bus_req    (bus_req),
   .bus_cmd    (bus_cmd),
   .bus_addr   (bus_addr),
   .bus_gnt    (bus_gnt),
   .snp_valid  (snp_valid),
   .snp_cmd    (snp_cmd),
   .rply_valid (rply_valid)
);

// File: tb/msi_snoop_ctrl_bench.sv
module msi_snoop_ctrl_bench;

   localparam int CLK_P  = 10;
   localparam int LINES  = 4;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_valid = 1'b0;
   logic              cpu_ready;
   logic [1:0]        cpu_op = '0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [DATA_W-1:0] cpu_wdata = '0;
   logic              cpu_done;
   logic [DATA_W-1:0] cpu_rdata;
   logic              bus_req;
   logic [2:0]        bus_cmd;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_wdata;
   logic              bus_gnt = 1'b0;
   logic [DATA_W-1:0] bus_fill = '0;
   logic              snp_valid = 1'b0;
   logic [2:0]        snp_cmd = '0;
   logic [ADDR_W-1:0] snp_addr = '0;
   logic              rply_valid;
   logic [ADDR_W-1:0] rply_addr;
   logic [DATA_W-1:0] rply_data;

   always #(CLK_P/2) clk = ~clk;

   msi_snoop_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_msi_snoop_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
      .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
      .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_gnt(bus_gnt), .bus_fill(bus_fill), .snp_valid(snp_valid),
      .snp_cmd(snp_cmd), .snp_addr(snp_addr), .rply_valid(rply_valid),
      .rply_addr(rply_addr), .rply_data(rply_data)
   );

   int n_chk = 0;
   int n_err = 0;
   bit fin = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   // states: 0 absent, 1 shared, 2 owned-dirty
   int m_st [LINES];
   int m_tag[LINES];
   int m_dat[LINES];
   bit m_pend;
   int m_op, m_addr, m_wd;
   bit e_done, e_load;
   int e_rdata;
   bit e_rply;
   int e_raddr, e_rdat;

   function automatic void mplan(output int cmd, output bit vic, output int nst,
                                 output int sel, output bit wr);
      int i, t, eff;
      bit hit;
      i   = m_addr % LINES;
      t   = m_addr / LINES;
      hit = (m_tag[i] == t);
      eff = hit ? m_st[i] : 0;
      cmd = 0; vic = 0; nst = m_st[i]; sel = 0; wr = 0;
      if (!hit && m_st[i] == 2 && m_op != 2) begin
         cmd = 4; vic = 1; nst = 0; wr = 1;
      end else if (m_op == 1) begin
         nst = 2; sel = 2; wr = 1;
         cmd = (eff == 0) ? 2 : (eff == 1) ? 3 : 0;
      end else if (m_op == 2) begin
         if (eff == 2) begin cmd = 4; nst = 0; wr = 1; end
         else if (eff == 1) begin nst = 0; wr = 1; end
      end else if (eff == 0) begin
         cmd = 1; nst = 1; sel = 1; wr = 1;
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) begin
            m_st[i] = 0; m_tag[i] = 0; m_dat[i] = 0;
         end
         m_pend = 0; e_done = 0; e_rply = 0; e_rdata = 0; e_load = 0;
         e_raddr = 0; e_rdat = 0; m_op = 0; m_addr = 0; m_wd = 0;
      end else begin
         bit nd, nr, cap;
         nd = 0; nr = 0;
         cap = !m_pend && cpu_valid;
         if (snp_valid) begin
            int i, t;
            i = int'(snp_addr) % LINES;
            t = int'(snp_addr) / LINES;
            if (m_st[i] != 0 && m_tag[i] == t) begin
               if (snp_cmd == 3'd1 && m_st[i] == 2) begin
                  nr = 1; e_raddr = int'(snp_addr); e_rdat = m_dat[i]; m_st[i] = 1;
               end else if (snp_cmd == 3'd2) begin
                  if (m_st[i] == 2) begin
                     nr = 1; e_raddr = int'(snp_addr); e_rdat = m_dat[i];
                  end
                  m_st[i] = 0;
               end else if (snp_cmd == 3'd3) begin
                  m_st[i] = 0;
               end
            end
         end else if (m_pend) begin
            int cmd, nst, sel, i;
            bit vic, wr;
            mplan(cmd, vic, nst, sel, wr);
            i = m_addr % LINES;
            if (cmd == 0 || bus_gnt) begin
               if (wr) begin
                  m_st[i]  = nst;
                  m_tag[i] = m_addr / LINES;
                  if (sel == 1) m_dat[i] = int'(bus_fill);
                  else if (sel == 2) m_dat[i] = m_wd;
               end
               if (!vic) begin
                  nd = 1; e_rdata = m_dat[i];
                  e_load = (m_op == 0 || m_op == 3);
                  m_pend = 0;
               end
            end
         end
         if (cap) begin
            m_pend = 1; m_op = int'(cpu_op); m_addr = int'(cpu_addr); m_wd = int'(cpu_wdata);
         end
         e_done = nd;
         e_rply = nr;
      end
   end

   // compare against the model on every falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         int cmd, nst, sel;
         bit vic, wr, ereq;
         int eaddr;
         cmd = 0; vic = 0;
         if (m_pend) mplan(cmd, vic, nst, sel, wr);
         ereq = m_pend && cmd != 0;
         chk(cpu_ready == !m_pend, "R12 model ready", int'(cpu_ready), int'(!m_pend));
         chk(bus_req == ereq, "R2 model bus_req", int'(bus_req), int'(ereq));
         if (ereq) begin
            eaddr = vic ? (m_tag[m_addr % LINES] * LINES + m_addr % LINES) : m_addr;
            chk(int'(bus_cmd) == cmd, "R2 model bus_cmd", int'(bus_cmd), cmd);
            chk(int'(bus_addr) == eaddr, "R7 model bus_addr", int'(bus_addr), eaddr);
            if (cmd == 4)
               chk(int'(bus_wdata) == m_dat[m_addr % LINES], "R6 model wb data",
                   int'(bus_wdata), m_dat[m_addr % LINES]);
         end
         chk(cpu_done == e_done, "R5 model done", int'(cpu_done), int'(e_done));
         if (e_done && e_load)
            chk(int'(cpu_rdata) == e_rdata, "R5 model rdata", int'(cpu_rdata), e_rdata);
         chk(rply_valid == e_rply, "R8 model reply", int'(rply_valid), int'(e_rply));
         if (e_rply) begin
            chk(int'(rply_addr) == e_raddr, "R8 model reply addr", int'(rply_addr), e_raddr);
            chk(int'(rply_data) == e_rdat, "R9 model reply data", int'(rply_data), e_rdat);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc();
      @(negedge clk);
      cpu_valid = 0; bus_gnt = 0; snp_valid = 0;
   endtask

   task automatic req(input int op, input int a, input int wd);
      cpu_valid = 1; cpu_op = 2'(op); cpu_addr = ADDR_W'(a); cpu_wdata = DATA_W'(wd);
      cyc();
   endtask

   task automatic gnt(input int fill);
      bus_gnt = 1; bus_fill = DATA_W'(fill);
      cyc();
   endtask

   task automatic snoop(input int c, input int a);
      snp_valid = 1; snp_cmd = 3'(c); snp_addr = ADDR_W'(a);
      cyc();
   endtask

   task automatic exp_req(input int c, input int a, input string r);
      chk(bus_req == 1'b1, r, int'(bus_req), 1);
      chk(int'(bus_cmd) == c, r, int'(bus_cmd), c);
      chk(int'(bus_addr) == a, r, int'(bus_addr), a);
   endtask

   task automatic exp_done(input bit rd, input int d, input string r);
      chk(cpu_done == 1'b1, r, int'(cpu_done), 1);
      if (rd) chk(int'(cpu_rdata) == d, r, int'(cpu_rdata), d);
   endtask

   localparam int A = 8'h04, B = 8'h08, C = 8'h01;

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(cpu_ready == 1'b1, "R1 ready after reset", int'(cpu_ready), 1);
      chk(bus_req == 1'b0, "R1 no request after reset", int'(bus_req), 0);
      chk(cpu_done == 1'b0, "R1 no done after reset", int'(cpu_done), 0);
      chk(rply_valid == 1'b0, "R1 no reply after reset", int'(rply_valid), 0);

      req(0, A, 0);       exp_req(1, A, "R1 first load reads bus");
      gnt(16'h1111);      exp_done(1, 16'h1111, "R2 load miss fill");
      req(0, A, 0);       chk(!bus_req, "R5 load hit no bus", int'(bus_req), 0);
      cyc();              exp_done(1, 16'h1111, "R5 load hit data");
      req(1, A, 16'h2222); exp_req(3, A, "R4 store on shared invalidates");
      gnt(0);             exp_done(0, 0, "R4 store on shared done");
      req(1, A, 16'h3333); chk(!bus_req, "R5 store hit on owned", int'(bus_req), 0);
      cyc();              exp_done(0, 0, "R5 store hit done");

      snoop(1, A);
      chk(rply_valid && rply_data == 16'h3333 && rply_addr == A, "R8 reply on read",
          int'(rply_data), 16'h3333);
      req(1, A, 16'h4444); exp_req(3, A, "R8 line left shared");
      gnt(0);
      snoop(2, A);
      chk(rply_valid && rply_data == 16'h4444, "R9 reply on read-exclusive",
          int'(rply_data), 16'h4444);
      req(0, A, 0);       exp_req(1, A, "R9 line invalid after read-exclusive");
      gnt(16'h5555);      exp_done(1, 16'h5555, "R9 refill");

      snoop(4, A);        chk(!rply_valid, "R10 write-back snoop ignored", int'(rply_valid), 0);
      snoop(3, B);        chk(!rply_valid, "R10 other tag ignored", int'(rply_valid), 0);
      req(0, A, 0);       chk(!bus_req, "R10 line kept", int'(bus_req), 0);
      cyc();              exp_done(1, 16'h5555, "R10 data kept");
      snoop(3, A);
      req(0, A, 0);       exp_req(1, A, "R10 invalidate snoop drops line");
      gnt(16'h6666);
      snoop(2, A);        chk(!rply_valid, "R9 shared gives no reply", int'(rply_valid), 0);
      req(0, A, 0);       exp_req(1, A, "R9 shared dropped by read-exclusive");
      gnt(16'h6666);

      // snoop in the grant cycle while a store waits
      req(1, A, 16'h7777); exp_req(3, A, "R11 store waits with invalidate");
      cyc();              exp_req(3, A, "R12 request held");
      snp_valid = 1; snp_cmd = 3'd2; snp_addr = A; bus_gnt = 1;
      cpu_valid = 1; cpu_op = 2'd1; cpu_addr = C; cpu_wdata = 16'hBEEF;
      cyc();
      chk(!cpu_done, "R11 grant ignored under snoop", int'(cpu_done), 0);
      chk(int'(bus_cmd) == 2, "R11 replanned to read-exclusive", int'(bus_cmd), 2);
      chk(!cpu_ready, "R12 busy while pending", int'(cpu_ready), 0);
      gnt(16'h0);         exp_done(0, 0, "R11 completes after replan");
      cyc();
      chk(!bus_req && cpu_ready, "R12 ignored request not started", int'(bus_req), 0);

      req(0, B, 0);       exp_req(4, A, "R7 victim write-back first");
      chk(int'(bus_wdata) == 16'h7777, "R7 victim data", int'(bus_wdata), 16'h7777);
      gnt(0);
      chk(!cpu_done, "R7 not done after victim", int'(cpu_done), 0);
      exp_req(1, B, "R7 then miss read");
      gnt(16'h8888);      exp_done(1, 16'h8888, "R7 conflict load data");

      req(2, B, 0);       chk(!bus_req, "R6 shared evict silent", int'(bus_req), 0);
      cyc();              exp_done(0, 0, "R6 shared evict done");
      req(0, B, 0);       exp_req(1, B, "R6 evicted line absent");
      gnt(16'h9999);
      req(1, C, 16'hAAAA); exp_req(2, C, "R3 store miss read-exclusive");
      gnt(16'h1234);      exp_done(0, 0, "R3 store miss done");
      req(0, C, 0);       chk(!bus_req, "R3 owned after store miss", int'(bus_req), 0);
      cyc();              exp_done(1, 16'hAAAA, "R3 store data kept");
      req(2, C, 0);       exp_req(4, C, "R6 dirty evict writes back");
      chk(int'(bus_wdata) == 16'hAAAA, "R6 write-back data", int'(bus_wdata), 16'hAAAA);
      gnt(0);             exp_done(0, 0, "R6 dirty evict done");
      req(0, C, 0);       exp_req(1, C, "R6 line absent after evict");
      gnt(0);
      req(2, 8'h02, 0);   chk(!bus_req, "R6 absent evict silent", int'(bus_req), 0);
      cyc();              exp_done(0, 0, "R6 absent evict done");

      // random phase, checked by the model every cycle
      for (int k = 0; k < 5000; k++) begin
         int addrs[5];
         addrs = '{8'h04, 8'h08, 8'h01, 8'h05, 8'h02};
         if (cpu_ready && ($urandom % 2 == 0)) begin
            cpu_valid = 1;
            cpu_op    = 2'($urandom % 3);
            cpu_addr  = ADDR_W'(addrs[$urandom % 5]);
            cpu_wdata = DATA_W'($urandom);
         end
         if (bus_req && ($urandom % 3 == 0)) begin
            bus_gnt  = 1;
            bus_fill = DATA_W'($urandom);
         end
         if ($urandom % 5 == 0) begin
            snp_valid = 1;
            snp_cmd   = 3'(1 + $urandom % 5);
            snp_addr  = ADDR_W'(addrs[$urandom % 5]);
         end
         cyc();
      end

      fin = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule